// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects requests from 41 peripheral sources and decides which one, if any, is offered to the processor core. Each source has a sticky request flag, an enable bit and a 3-bit priority field, all held in a small register file behind a single-cycle write port. Every cycle the block finds the best eligible source and compares its priority with the current CPU level. It then offers the core a registered vector number, the priority level that would follow acceptance, and the fetch address of the vector entry. That address is taken from either the primary or the alternate vector table.

The core accepts an offer with a one-cycle `ack` pulse. On acceptance the block saves the old CPU level on a small level stack, raises the CPU level to the priority of the accepted request, and records the vector number and new level in status outputs. A one-cycle `ret` pulse restores the saved level. Two mechanisms narrow what can be taken. A no-nesting mode refuses every request while one is in service and also freezes the CPU level against software writes. A counted disable window, loaded by a register write and shortened by one on each retired-instruction pulse, blocks every request below the top priority.

Top module: `vic_top`

## Requirements
- R1: A source pulse sets that source's flag whatever its enable bit. The flag then stays set until a write to its flag word (address 0 + i/16, bit i%16) stores a 0 there. A source pulse in the same cycle as such a write wins.
- R2: A source is eligible only when its flag is set, its enable bit (address 4 + i/16, bit i%16) is set, its priority (address 16 + i/4, bits 4*(i%4)+2 down to 4*(i%4)) is nonzero, and that priority is strictly greater than the CPU level. The CPU level is written at address 33, bits 3:0. `irq_valid` follows eligibility one clock after the state changes.
- R3: Among eligible sources the highest priority wins. A tie goes to the lowest source index.
- R4: `irq_vec` equals the source index plus 8. `irq_addr` equals the table base plus twice `irq_vec`. The base is 0x000004 when bit 1 of the control word (address 32) is clear, and 0x000084 when it is set.
- R5: An `ack` while `irq_valid` is high does four things: it latches `irq_vec` and `irq_lvl` into `stat_vec` and `stat_lvl`, sets `cpu_lvl` to `irq_lvl`, raises `in_service`, and drops `irq_valid` for the following cycle. After reset all outputs are zero.
- R6: A `ret` pulse while in service restores the CPU level saved by the matching acceptance. `in_service` falls once every accepted request has returned.
- R7: With control bit 0 (no-nesting) set, no request is offered while `in_service` is high, whatever its priority. Writes to the CPU level are ignored in that mode.
- R8: A write to address 34 loads the window counter. `win_active` is high while the counter is nonzero. Each `instr_ret` pulse lowers the counter by one. While the window is active only priority-7 requests are offered. Reloading during the window restarts it.
- R9: With the level stack full (STACK_DEPTH acceptances outstanding) no request is offered until a return frees an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_evt | input | NSRC | One-cycle request pulses, one per source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register word address |
| wr_data | input | 16 | Register write data |
| ack | input | 1 | Core accepts the offered request |
| ret | input | 1 | Core returns from the current handler |
| instr_ret | input | 1 | One pulse per retired instruction |
| irq_valid | output | 1 | A request is offered |
| irq_vec | output | 6 | Offered vector number |
| irq_lvl | output | 4 | CPU level that acceptance would set |
| irq_addr | output | FETCH_W | Vector entry fetch address |
| cpu_lvl | output | 4 | Current CPU priority level |
| stat_vec | output | 6 | Vector number of the last acceptance |
| stat_lvl | output | 4 | Level set by the last acceptance |
| in_service | output | 1 | At least one accepted request is outstanding |
| win_active | output | 1 | Disable window is running |

## Verification
The bench keeps the default 41 sources, so sources in all three flag words and in the last partial priority word are reachable. STACK_DEPTH is lowered to 2, so the full-stack block appears after two nested acceptances, and CNT_W is lowered to 8. With these values, window reloads, restarts and expiry all fit in a few retire pulses, and nested level restore can be checked at each depth.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int WADDR_W = 6;
  localparam int WDATA_W = 16;
  localparam int LVL_W   = 4;
  localparam int PRIO_W  = 3;
  localparam int VEC_W   = 6;

  localparam int PRIO_MAX = (1 << PRIO_W) - 1;

  // register word addresses
  localparam int A_FLAG0 = 0;
  localparam int A_EN0   = 4;
  localparam int A_PRIO0 = 16;
  localparam int A_CTRL  = 32;
  localparam int A_LVL   = 33;
  localparam int A_WIN   = 34;

  localparam int SRC_PER_WORD  = 16;
  localparam int SRC_PER_PWORD = 4;
  localparam int PFIELD_W      = 4;

  typedef struct packed {
    logic             valid;
    logic [VEC_W-1:0] vec;
    logic [LVL_W-1:0] lvl;
  } pick_t;
endpackage

// File: rtl/vic_src_regs.sv
module vic_src_regs
  import vic_pkg::*;
#(
  parameter int NSRC = 41
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NSRC-1:0]               src_evt,
  input  logic                          wr_en,
  input  logic [WADDR_W-1:0]            wr_addr,
  input  logic [WDATA_W-1:0]            wr_data,
  output logic [NSRC-1:0]               flag_q,
  output logic [NSRC-1:0]               en_q,
  output logic [NSRC-1:0][PRIO_W-1:0]   prio_q
);
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    localparam int FW = i / SRC_PER_WORD;
    localparam int FB = i % SRC_PER_WORD;
    localparam int PW = i / SRC_PER_PWORD;
    localparam int PB = (i % SRC_PER_PWORD) * PFIELD_W;

    logic flag_wr, en_wr, prio_wr;
    assign flag_wr = wr_en && (wr_addr == WADDR_W'(A_FLAG0 + FW));
    assign en_wr   = wr_en && (wr_addr == WADDR_W'(A_EN0 + FW));
    assign prio_wr = wr_en && (wr_addr == WADDR_W'(A_PRIO0 + PW));

    always_ff @(posedge clk) begin
      if (rst) begin
        flag_q[i] <= 1'b0;
        en_q[i]   <= 1'b0;
        prio_q[i] <= '0;
      end else begin
        if (src_evt[i])   flag_q[i] <= 1'b1;
        else if (flag_wr) flag_q[i] <= wr_data[FB];
        if (en_wr)        en_q[i]   <= wr_data[FB];
        if (prio_wr)      prio_q[i] <= wr_data[PB +: PRIO_W];
      end
    end

    // R1: an event always leaves the flag set
    p_flag_set_r1: assert property (@(posedge clk) disable iff (rst)
      src_evt[i] |=> flag_q[i]) else $error("flag not set by event");
    // R1: without a write to its word the flag cannot fall
    p_flag_hold_r1: assert property (@(posedge clk) disable iff (rst)
      (flag_q[i] && !flag_wr) |=> flag_q[i]) else $error("flag fell without write");
  end
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
  import vic_pkg::*;
#(
  parameter int NSRC    = 41,
  parameter int VEC_OFS = 8
) (
  input  logic [NSRC-1:0]             flag_q,
  input  logic [NSRC-1:0]             en_q,
  input  logic [NSRC-1:0][PRIO_W-1:0] prio_q,
  input  logic [LVL_W-1:0]            cpu_lvl,
  input  logic                        block_all,
  input  logic                        mask_low,
  output pick_t                       pick
);
  logic              found;
  logic [PRIO_W-1:0] best_p;
  logic [VEC_W-1:0]  best_i;
  logic              elig;

  // R2/R3: linear scan, strict greater-than keeps the lowest index on ties
  always_comb begin
    found  = 1'b0;
    best_p = '0;
    best_i = '0;
    elig   = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      elig = flag_q[i] && en_q[i] && (prio_q[i] != '0)
             && (LVL_W'(prio_q[i]) > cpu_lvl)
             && !(mask_low && (prio_q[i] != PRIO_W'(PRIO_MAX)));
      if (elig && (!found || prio_q[i] > best_p)) begin
        found  = 1'b1;
        best_p = prio_q[i];
        best_i = VEC_W'(i);
      end
    end
    pick.valid = found && !block_all;
    pick.vec   = best_i + VEC_W'(VEC_OFS);
    pick.lvl   = LVL_W'(best_p);
  end
endmodule

// File: rtl/vic_level_stack.sv
module vic_level_stack
  import vic_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [LVL_W-1:0] push_lvl,
  input  logic             pop,
  input  logic             sw_wr,
  input  logic [LVL_W-1:0] sw_lvl,
  input  logic             sw_lock,
  output logic [LVL_W-1:0] cpu_lvl,
  output logic             full,
  output logic             in_service
);
  localparam int DW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [LVL_W-1:0] stk [DEPTH];
  logic [DW-1:0]    depth;
  logic [IW-1:0]    wr_idx, rd_idx;

  assign wr_idx     = IW'(depth);
  assign rd_idx     = IW'(depth - DW'(1));
  assign full       = (depth == DW'(DEPTH));
  assign in_service = (depth != '0);

  // storage without reset so it may map onto RAM
  always_ff @(posedge clk) begin
    if (push && !full) stk[wr_idx] <= cpu_lvl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_lvl <= '0;
      depth   <= '0;
    end else if (push && !full) begin
      cpu_lvl <= push_lvl;
      depth   <= depth + DW'(1);
    end else if (pop && in_service) begin
      cpu_lvl <= stk[rd_idx];
      depth   <= depth - DW'(1);
    end else if (sw_wr && !sw_lock) begin
      cpu_lvl <= sw_lvl;
    end
  end

  p_depth_bound_r9: assert property (@(posedge clk) disable iff (rst)
    depth <= DW'(DEPTH)) else $error("stack depth overrun");
  p_push_service_r5: assert property (@(posedge clk) disable iff (rst)
    (push && !full) |=> in_service) else $error("no in-service after push");
  p_lock_r7: assert property (@(posedge clk) disable iff (rst)
    (sw_wr && sw_lock && !push && !pop) |=> $stable(cpu_lvl)) else $error("locked level changed");
endmodule

// File: rtl/vic_disable_timer.sv
module vic_disable_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             active
);
  logic [CNT_W-1:0] count;

  assign active = (count != '0);

  always_ff @(posedge clk) begin
    if (rst)                 count <= '0;
    else if (load)           count <= load_val;
    else if (tick && active) count <= count - CNT_W'(1);
  end

  p_tick_dec_r8: assert property (@(posedge clk) disable iff (rst)
    (tick && active && !load) |=> (count == $past(count) - CNT_W'(1))) else $error("window did not count");
  p_reload_r8: assert property (@(posedge clk) disable iff (rst)
    load |=> (count == $past(load_val))) else $error("window reload lost");
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int              NSRC        = 41,
  parameter int              STACK_DEPTH = 4,
  parameter int              CNT_W       = 16,
  parameter int              VEC_OFS     = 8,
  parameter int              FETCH_W     = 24,
  parameter logic [FETCH_W-1:0] PRI_BASE = 24'h000004,
  parameter logic [FETCH_W-1:0] ALT_OFS  = 24'h000080
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NSRC-1:0]    src_evt,
  input  logic               wr_en,
  input  logic [5:0]         wr_addr,
  input  logic [15:0]        wr_data,
  input  logic               ack,
  input  logic               ret,
  input  logic               instr_ret,
  output logic               irq_valid,
  output logic [5:0]         irq_vec,
  output logic [3:0]         irq_lvl,
  output logic [FETCH_W-1:0] irq_addr,
  output logic [3:0]         cpu_lvl,
  output logic [5:0]         stat_vec,
  output logic [3:0]         stat_lvl,
  output logic               in_service,
  output logic               win_active
);
  localparam logic [FETCH_W-1:0] ALT_BASE = PRI_BASE + ALT_OFS;

  logic [NSRC-1:0]             flag_q, en_q;
  logic [NSRC-1:0][PRIO_W-1:0] prio_q;
  logic                        nonest_q, alt_q;
  logic                        stk_full;
  logic                        ack_fire;
  pick_t                       pick;
  logic [FETCH_W-1:0]          tbl_base;

  vic_src_regs #(.NSRC(NSRC)) u_regs (
    .clk(clk), .rst(rst), .src_evt(src_evt),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .flag_q(flag_q), .en_q(en_q), .prio_q(prio_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      nonest_q <= 1'b0;
      alt_q    <= 1'b0;
    end else if (wr_en && wr_addr == WADDR_W'(A_CTRL)) begin
      nonest_q <= wr_data[0];
      alt_q    <= wr_data[1];
    end
  end

  vic_arbiter #(.NSRC(NSRC), .VEC_OFS(VEC_OFS)) u_arb (
    .flag_q(flag_q), .en_q(en_q), .prio_q(prio_q), .cpu_lvl(cpu_lvl),
    .block_all((nonest_q && in_service) || stk_full),
    .mask_low(win_active), .pick(pick)
  );

  assign ack_fire = ack && irq_valid && !ret;

  vic_level_stack #(.DEPTH(STACK_DEPTH)) u_stack (
    .clk(clk), .rst(rst), .push(ack_fire), .push_lvl(irq_lvl), .pop(ret),
    .sw_wr(wr_en && wr_addr == WADDR_W'(A_LVL)), .sw_lvl(wr_data[LVL_W-1:0]),
    .sw_lock(nonest_q), .cpu_lvl(cpu_lvl), .full(stk_full), .in_service(in_service)
  );

  vic_disable_timer #(.CNT_W(CNT_W)) u_win (
    .clk(clk), .rst(rst), .load(wr_en && wr_addr == WADDR_W'(A_WIN)),
    .load_val(CNT_W'(wr_data)), .tick(instr_ret), .active(win_active)
  );

  assign tbl_base = alt_q ? ALT_BASE : PRI_BASE;

  // registered offer; dropped for one cycle after acceptance
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_valid <= 1'b0;
      irq_vec   <= '0;
      irq_lvl   <= '0;
      irq_addr  <= '0;
      stat_vec  <= '0;
      stat_lvl  <= '0;
    end else begin
      irq_valid <= pick.valid && !ack_fire;
      irq_vec   <= pick.vec;
      irq_lvl   <= pick.lvl;
      irq_addr  <= tbl_base + FETCH_W'({pick.vec, 1'b0});
      if (ack_fire) begin
        stat_vec <= irq_vec;
        stat_lvl <= irq_lvl;
      end
    end
  end

  p_valid_above_r2: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (irq_lvl > $past(cpu_lvl))) else $error("offer not above level");
  p_ack_level_r5: assert property (@(posedge clk) disable iff (rst)
    ack_fire |=> (cpu_lvl == $past(irq_lvl))) else $error("level not raised");
  p_ack_drop_r5: assert property (@(posedge clk) disable iff (rst)
    ack_fire |=> !irq_valid) else $error("offer held after ack");
  p_nonest_block_r7: assert property (@(posedge clk) disable iff (rst)
    (nonest_q && in_service) |=> !irq_valid) else $error("nested under no-nest");
  p_window_mask_r8: assert property (@(posedge clk) disable iff (rst)
    win_active |=> (!irq_valid || irq_lvl == LVL_W'(PRIO_MAX))) else $error("low level in window");
  p_full_block_r9: assert property (@(posedge clk) disable iff (rst)
    stk_full |=> !irq_valid) else $error("offer with full stack");
endmodule

// File: tb/vic_top_bench.sv
module vic_top_bench;
  localparam int NSRC = 41;

  typedef struct {
    int    vec;
    int    lvl;
    int    addr;
    string tag;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NSRC-1:0] src_evt = '0;
  logic            wr_en = 1'b0;
  logic [5:0]      wr_addr = '0;
  logic [15:0]     wr_data = '0;
  logic            ack = 1'b0, ret = 1'b0, instr_ret = 1'b0;
  logic            irq_valid;
  logic [5:0]      irq_vec;
  logic [3:0]      irq_lvl;
  logic [23:0]     irq_addr;
  logic [3:0]      cpu_lvl;
  logic [5:0]      stat_vec;
  logic [3:0]      stat_lvl;
  logic            in_service, win_active;

  int   n_cmp = 0, n_bad = 0;
  bit   done = 0;
  exp_t q[$];
  exp_t mon_e;
  logic [15:0] en_sh [3];
  logic [15:0] ps_sh [11];

  always #5 clk = ~clk;

  vic_top #(.NSRC(NSRC), .STACK_DEPTH(2), .CNT_W(8)) u_vic_top (
    .clk(clk), .rst(rst), .src_evt(src_evt), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ack(ack), .ret(ret), .instr_ret(instr_ret),
    .irq_valid(irq_valid), .irq_vec(irq_vec), .irq_lvl(irq_lvl), .irq_addr(irq_addr),
    .cpu_lvl(cpu_lvl), .stat_vec(stat_vec), .stat_lvl(stat_lvl),
    .in_service(in_service), .win_active(win_active)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // scoreboard monitor: every accepted offer is compared with the queue head
  always @(negedge clk) begin
    #1;
    if (ack && irq_valid) begin
      if (q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R5 unexpected acceptance: actual vec %0d expected none", irq_vec);
      end else begin
        mon_e = q.pop_front();
        check({mon_e.tag, " vec"},  int'(irq_vec),  mon_e.vec);
        check({mon_e.tag, " lvl"},  int'(irq_lvl),  mon_e.lvl);
        check({mon_e.tag, " addr"}, int'(irq_addr), mon_e.addr);
      end
    end
  end

  task automatic wr(input int a, input int d);
    wr_en = 1; wr_addr = 6'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic set_src(input int i, input bit e, input int p);
    en_sh[i/16][i%16] = e;
    wr(4 + i/16, int'(en_sh[i/16]));
    ps_sh[i/4][(i%4)*4 +: 3] = 3'(p);
    wr(16 + i/4, int'(ps_sh[i/4]));
  endtask

  task automatic pulse_src(input int i);
    src_evt[i] = 1'b1;
    @(negedge clk);
    src_evt = '0;
  endtask

  task automatic ret_pulse();
    ret = 1;
    @(negedge clk);
    ret = 0;
  endtask

  task automatic tick();
    instr_ret = 1;
    @(negedge clk);
    instr_ret = 0;
  endtask

  task automatic idle(input string tag);
    repeat (3) @(negedge clk);
    check({tag, " no offer"}, int'(irq_valid), 0);
  endtask

  // driver: queue the expected offer, wait for it, accept it
  task automatic take(input int vec, input int lvl, input int addr, input string tag);
    exp_t e;
    int   w;
    e.vec = vec; e.lvl = lvl; e.addr = addr; e.tag = tag;
    q.push_back(e);
    w = 0;
    while (!irq_valid && w < 12) begin
      @(negedge clk);
      w++;
    end
    if (!irq_valid) begin
      n_cmp++; n_bad++;
      $display("FAIL %s offer: actual none expected vec %0d", tag, vec);
      void'(q.pop_back());
    end else begin
      ack = 1;
      @(negedge clk);
      ack = 0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    report();
  end

  initial begin
    for (int k = 0; k < 3; k++) en_sh[k] = '0;
    for (int k = 0; k < 11; k++) ps_sh[k] = '0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // reset state (R5)
    check("R5 reset valid", int'(irq_valid), 0);
    check("R5 reset cpu_lvl", int'(cpu_lvl), 0);
    check("R5 reset in_service", int'(in_service), 0);
    check("R8 reset window", int'(win_active), 0);

    // R1 sticky flag set while disabled
    pulse_src(5);
    idle("R1 disabled source");
    set_src(5, 1, 3);
    take(13, 3, 30, "R1 sticky");
    check("R5 cpu_lvl raised", int'(cpu_lvl), 3);
    check("R5 stat_vec", int'(stat_vec), 13);
    check("R5 stat_lvl", int'(stat_lvl), 3);
    check("R5 in_service", int'(in_service), 1);
    wr(0, 0);
    ret_pulse();
    check("R6 level restored", int'(cpu_lvl), 0);
    check("R6 in_service clear", int'(in_service), 0);
    idle("R1 cleared flag");

    // R2 priority zero, equal level, higher level
    set_src(7, 1, 0);
    pulse_src(7);
    idle("R2 priority zero");
    wr(33, 4);
    check("R2 level write", int'(cpu_lvl), 4);
    set_src(7, 1, 4);
    idle("R2 equal priority");
    set_src(7, 1, 5);
    take(15, 5, 34, "R2 above level");
    ret_pulse();
    check("R6 level back to 4", int'(cpu_lvl), 4);
    wr(0, 0);
    wr(33, 0);

    // R3 highest priority, tie to lowest index
    set_src(20, 1, 6);
    set_src(30, 1, 6);
    set_src(3, 1, 2);
    pulse_src(20); pulse_src(30); pulse_src(3);
    take(28, 6, 60, "R3 tie low index");
    wr(1, 16'h4000);
    idle("R3 equal not nested");
    ret_pulse();
    take(38, 6, 80, "R3 second of tie");
    wr(1, 0);
    ret_pulse();
    take(11, 3 - 1, 26, "R3 lowest remaining");
    wr(0, 0);
    ret_pulse();

    // R4 alternate table
    wr(32, 2);
    set_src(40, 1, 1);
    pulse_src(40);
    take(48, 1, 228, "R4 alt table");
    wr(2, 0);
    ret_pulse();
    wr(32, 0);

    // R9 nesting up to a full stack
    set_src(1, 1, 2);
    set_src(2, 1, 4);
    set_src(0, 1, 7);
    pulse_src(1);
    take(9, 2, 22, "R6 outer");
    pulse_src(2);
    take(10, 4, 24, "R6 nested");
    pulse_src(0);
    idle("R9 stack full");
    ret_pulse();
    check("R6 nested restore", int'(cpu_lvl), 2);
    take(8, 7, 20, "R9 after free");
    wr(0, 0);
    ret_pulse();
    check("R6 restore after top", int'(cpu_lvl), 2);
    ret_pulse();
    check("R6 restore outer", int'(cpu_lvl), 0);
    check("R6 all returned", int'(in_service), 0);

    // R7 no-nesting
    wr(32, 1);
    pulse_src(1);
    take(9, 2, 22, "R7 first");
    pulse_src(2);
    idle("R7 higher blocked");
    wr(33, 9);
    check("R7 level write ignored", int'(cpu_lvl), 2);
    wr(0, 16'h0004);
    ret_pulse();
    take(10, 4, 24, "R7 after return");
    wr(0, 0);
    ret_pulse();
    wr(32, 0);

    // R8 disable window
    set_src(4, 1, 6);
    set_src(6, 1, 7);
    wr(34, 3);
    check("R8 window on", int'(win_active), 1);
    pulse_src(4);
    idle("R8 level 6 masked");
    pulse_src(6);
    take(14, 7, 32, "R8 level 7 passes");
    wr(0, 16'h0010);
    ret_pulse();
    idle("R8 still masked");
    tick(); tick();
    check("R8 active after two", int'(win_active), 1);
    wr(34, 3);
    tick(); tick();
    check("R8 reload restarts", int'(win_active), 1);
    tick();
    check("R8 window expired", int'(win_active), 0);
    take(12, 6, 28, "R8 after window");
    wr(0, 0);
    ret_pulse();

    repeat (3) @(negedge clk);
    check("R5 queue drained", q.size(), 0);
    report();
  end
endmodule